// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer

This block is a general-purpose timer for a microcontroller-style subsystem. A 16-bit up-counter advances on one of two kinds of tick. The first is an internal tick at the system clock divided by 2, 4 or 8. The second is a qualified edge on an external clock pin. Two capture channels copy the counter value when an edge arrives on their input pins. Two compare channels drive output pins to programmed levels when the counter reaches their values. The two compare values can also act together with capture channel 0 to produce a pulse-width-modulated waveform or a single triggered pulse.

Software reaches the timer through an 8-bit register bus. Every 16-bit quantity is split into a high byte and a low byte. Reading the counter's high byte freezes a copy of its low byte, so the two bytes always belong to the same count. Reading a capture register's high byte holds off new captures on that channel until its low byte is read. Five event flags share one interrupt line, and each flag has an enable.

Bus reads are combinational during the `bus_rd` cycle, and their side effects take place at the closing clock edge. Writes take effect at the edge of the `bus_wr` cycle.

Top module: `cct_timer`

## Requirements
- R1: Field CTRLB[1:0] (address 1) selects the tick source: 00 gives the clock divided by 2, 01 divided by 4, 10 divided by 8, and 11 the external pin. Over any 64-cycle window the internal ticks number exactly 64 divided by the ratio. The reset value of CTRLB is 0x00.
- R2: In external mode, CTRLA[7] (address 0) picks the counted edge of `ext_clk`, where 1 means rising and 0 means falling. The pin passes through a two-stage synchroniser. An edge of the other polarity does not advance the counter.
- R3: An external edge is counted only when at least 4 clock cycles have passed since the previously counted edge. A square wave with a 2-cycle period and 8 rising edges therefore advances the counter by 4.
- R4: The counter resets to 0xFFFC. A write of any value to address 6 (alternate count, low byte) returns it to 0xFFFC. Otherwise the counter only steps by one. After reset, CTRLA and STAT read 0x00 and both compare high bytes (addresses 11 and 13) read 0x80.
- R5: When the counter wraps from 0xFFFF to 0x0000, STAT[4] (address 2) sets.
- R6: Reading the counter high byte (address 3) stores the low byte. The next read of the counter low byte (address 4) returns that stored byte even if the counter has advanced. A later low-byte read returns the live value. Addresses 5 and 6 give the same view without any flag side effect.
- R7: On the edge of `cap_in[i]` selected by CTRLA[i] (1 means rising, 0 means falling), capture register i (address 7/8 for i=0, 9/10 for i=1, high/low) takes the counter value. STAT[i] sets at the same time.
- R8: Once capture register i's high byte has been read, further edges on `cap_in[i]` neither change the register nor set STAT[i]. This holds until its low byte is read.
- R9: In normal mode, a step of the counter onto compare value i (address 11/12 for i=0, 13/14 for i=1) has two effects. It sets STAT[2+i], and it drives pin i to level CTRLA[2+i]. `cmp_out[i]` shows the pin only when CTRLB[4+i] is 1.
- R10: With CTRLB[2]=1 (waveform mode), a tick at a count equal to compare value 1 restarts the counter at 0xFFFC and drives pin 0 to CTRLA[3]. A write to address 6 does the same. Stepping onto compare value 0 drives pin 0 to CTRLA[2]. STAT[2] and STAT[3] stay clear in this mode.
- R11: With CTRLB[3]=1 and CTRLB[2]=0 (single-pulse mode), a capture event on channel 0 restarts the counter at 0xFFFC and drives pin 0 to CTRLA[3]. Stepping onto compare value 0 then drives pin 0 to CTRLA[2].
- R12: A STAT flag clears only when two accesses happen in order. The first is a STAT read that saw the flag set. The second is an access to the low byte of the matching data register: a read of address 8 or 10 for captures, a read or write of address 12 or 14 for compares, or a read of address 4 for overflow.
- R13: `irq` is high while any flag is set with its enable. CTRLA[6] enables the capture flags, CTRLA[5] the compare flags and CTRLA[4] the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| ext_clk | input | 1 | External count clock |
| cap_in | input | 2 | Capture trigger pins, one per channel |
| cmp_out | output | 2 | Compare output pins, one per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check several rules on every cycle. The counter only ever steps by one or jumps to 0xFFFC. A wrap to zero always leaves the overflow flag set. External ticks are never closer than four cycles, and divide-by-8 ticks are never adjacent. A capture register cannot change while its channel is locked. Other behaviours depend on ordered register accesses and pin stimulus, so only the bench scenarios can show them. These include the coherent low-byte read, the two-step flag clearing, edge polarity, and the waveform and single-pulse sequences on the output pin.

// File: rtl/cct_pkg.sv
// Shared constants for the capture/compare timer: register addresses,
// tick source encoding and flag positions.
package cct_pkg;
    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int NCH    = 2;
    localparam int NFLAG  = 5;

    typedef enum logic [1:0] {
        SRC_DIV2 = 2'b00,
        SRC_DIV4 = 2'b01,
        SRC_DIV8 = 2'b10,
        SRC_EXT  = 2'b11
    } tick_src_e;

    localparam logic [ADDR_W-1:0] A_CTRLA    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRLB    = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT     = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd4;
    localparam logic [ADDR_W-1:0] A_ACNT_HI  = 4'd5;
    localparam logic [ADDR_W-1:0] A_ACNT_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAP0_HI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMP0_HI  = 4'd11;

    localparam logic [CNT_W-1:0] CNT_RST  = 16'hFFFC;
    localparam logic [CNT_W-1:0] CMP_RST  = 16'h8000;

    localparam int F_CAP0 = 0;
    localparam int F_CMP0 = 2;
    localparam int F_OVF  = 4;
endpackage

// File: rtl/cct_clkgen.sv
// Tick generator. Produces a one-cycle count enable either from a free
// prescaler (divide by 2, 4 or 8) or from a synchronised external clock
// edge that is at least MIN_GAP cycles after the previous accepted edge.
// Assumes ext_in is asynchronous to clk.
module cct_clkgen
    import cct_pkg::*;
#(
    parameter int MIN_GAP = 4,
    parameter int PRE_W   = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tick_src_e src,
    input  logic      ext_in,
    input  logic      ext_rise,
    output logic      tick
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [2:0]       ext_s;
    logic [GAP_W-1:0] gap_q;
    logic             ext_edge;
    logic             ext_ok;

    // free-running prescaler
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PRE_W'(1);
    end

    // two-stage synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_s <= '0;
        else        ext_s <= {ext_s[1:0], ext_in};
    end

    // prescaler mask for the selected ratio
    always_comb begin
        case (src)
            SRC_DIV2: mask = PRE_W'(1);
            SRC_DIV4: mask = PRE_W'(3);
            default:  mask = PRE_W'(7);
        endcase
    end

    assign ext_edge = ext_rise ? (ext_s[1] & ~ext_s[2]) : (~ext_s[1] & ext_s[2]);
    assign ext_ok   = ext_edge && (gap_q == GAP_W'(MIN_GAP));

    // cycles since the last accepted external edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_q <= GAP_W'(MIN_GAP);
        else if (ext_ok)                    gap_q <= GAP_W'(1);
        else if (gap_q != GAP_W'(MIN_GAP))  gap_q <= gap_q + GAP_W'(1);
    end

    assign tick = (src == SRC_EXT) ? ext_ok : ((pre_q & mask) == mask);
endmodule

// File: rtl/cct_capture.sv
// One capture channel: synchronises its pin, detects the chosen edge and
// latches the counter unless the channel is locked between a high-byte
// and a low-byte read. Assumes lock_set and lock_clr are never both high.
module cct_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic [W-1:0] cnt,
    input  logic         lock_set,
    input  logic         lock_clr,
    output logic [W-1:0] value,
    output logic         evt,
    output logic         locked
);
    logic [2:0] sync_q;
    logic       edge_det;

    // synchroniser and history stage
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign edge_det = rise_sel ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);
    assign evt      = edge_det && !locked;

    // lock between high and low byte reads
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b0;
        else if (lock_set) locked <= 1'b1;
        else if (lock_clr) locked <= 1'b0;
    end

    // capture register
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (evt) value <= cnt;
    end
endmodule

// File: rtl/cct_count_cmp.sv
// Counter and compare stage: the 16-bit up-counter with its restart
// sources, overflow and compare match detection, and the two pin levels
// in normal, waveform and single-pulse modes. Waveform mode has priority
// over single-pulse mode.
module cct_count_cmp #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         soft_rst,
    input  logic         pwm_en,
    input  logic         opm_en,
    input  logic         trig,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    input  logic         lvl0,
    input  logic         lvl1,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         m0_evt,
    output logic         m1_evt,
    output logic         pin0,
    output logic         pin1
);
    logic [W-1:0] inc;
    logic         pwm_wrap;
    logic         opm_start;
    logic         restart;
    logic         adv;
    logic         hit0;
    logic         hit1;

    assign inc       = cnt + W'(1);
    assign pwm_wrap  = pwm_en && tick && (cnt == cmp1);
    assign opm_start = opm_en && !pwm_en && trig;
    assign restart   = soft_rst || pwm_wrap || opm_start;
    assign adv       = tick && !restart;
    assign hit0      = adv && (inc == cmp0);
    assign hit1      = adv && (inc == cmp1);
    assign ovf_evt   = adv && (cnt == {W{1'b1}});
    assign m0_evt    = hit0 && !pwm_en;
    assign m1_evt    = hit1 && !pwm_en;

    // counter: restart or step
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= RST_VAL;
        else if (restart) cnt <= RST_VAL;
        else if (adv)     cnt <= inc;
    end

    // pin 0 level per mode
    always_ff @(posedge clk) begin
        if (!rst_n) pin0 <= 1'b0;
        else if (pwm_en) begin
            if (soft_rst || pwm_wrap) pin0 <= lvl1;
            else if (hit0)            pin0 <= lvl0;
        end else if (opm_start)       pin0 <= lvl1;
        else if (hit0)                pin0 <= lvl0;
    end

    // pin 1 level, normal mode only
    always_ff @(posedge clk) begin
        if (!rst_n)                 pin1 <= 1'b0;
        else if (!pwm_en && hit1)   pin1 <= lvl1;
    end
endmodule

// File: rtl/cct_timer.sv
// Capture/compare timer top: 8-bit register bus, byte buffering for the
// counter, flag set/clear sequencing, interrupt combine, and the tick,
// capture and counter/compare stages. Reads are combinational during
// the bus_rd cycle and their side effects occur at the closing edge.
module cct_timer
    import cct_pkg::*;
#(
    parameter int MIN_GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic [NCH-1:0]    cap_in,
    output logic [NCH-1:0]    cmp_out,
    output logic              irq
);
    localparam int HI = CNT_W - 1;

    logic [BYTE_W-1:0]           ctrla;
    logic [5:0]                  ctrlb;
    logic [NCH-1:0][CNT_W-1:0]   cmp_reg;
    logic [NCH-1:0][CNT_W-1:0]   cap_val;
    logic [NCH-1:0]              cap_evt;
    logic [NCH-1:0]              cap_inh;
    logic [NCH-1:0]              cap_hi_rd;
    logic [NCH-1:0]              cap_lo_rd;
    logic [NFLAG-1:0]            flags;
    logic [NFLAG-1:0]            armed;
    logic [NFLAG-1:0]            f_set;
    logic [NFLAG-1:0]            f_clr;
    logic [NFLAG-1:0]            f_en;
    logic [BYTE_W-1:0]           cnt_buf;
    logic [BYTE_W-1:0]           acnt_buf;
    logic                        cnt_bv;
    logic                        acnt_bv;
    logic [CNT_W-1:0]            cnt;
    logic                        tick;
    logic                        ovf_evt;
    logic                        m0_evt;
    logic                        m1_evt;
    logic                        pin0;
    logic                        pin1;
    tick_src_e                   src;

    function automatic logic hit(input logic strobe, input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] b);
        return strobe && (a == b);
    endfunction

    assign src = tick_src_e'(ctrlb[1:0]);

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrla <= '0;
            ctrlb <= '0;
        end else begin
            if (hit(bus_wr, bus_addr, A_CTRLA)) ctrla <= bus_wdata;
            if (hit(bus_wr, bus_addr, A_CTRLB)) ctrlb <= bus_wdata[5:0];
        end
    end

    // compare register byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_reg <= {NCH{CMP_RST}};
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (hit(bus_wr, bus_addr, A_CMP0_HI + ADDR_W'(2 * i)))
                    cmp_reg[i][HI:BYTE_W] <= bus_wdata;
                if (hit(bus_wr, bus_addr, A_CMP0_HI + ADDR_W'(2 * i + 1)))
                    cmp_reg[i][BYTE_W-1:0] <= bus_wdata;
            end
        end
    end

    // coherent low-byte buffers for the two counter views
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_buf  <= '0;
            acnt_buf <= '0;
            cnt_bv   <= 1'b0;
            acnt_bv  <= 1'b0;
        end else begin
            if (hit(bus_rd, bus_addr, A_CNT_HI)) begin
                cnt_buf <= cnt[BYTE_W-1:0];
                cnt_bv  <= 1'b1;
            end else if (hit(bus_rd, bus_addr, A_CNT_LO)) begin
                cnt_bv  <= 1'b0;
            end
            if (hit(bus_rd, bus_addr, A_ACNT_HI)) begin
                acnt_buf <= cnt[BYTE_W-1:0];
                acnt_bv  <= 1'b1;
            end else if (hit(bus_rd, bus_addr, A_ACNT_LO)) begin
                acnt_bv  <= 1'b0;
            end
        end
    end

    // capture channels
    for (genvar g = 0; g < NCH; g++) begin : g_cap
        assign cap_hi_rd[g] = hit(bus_rd, bus_addr, A_CAP0_HI + ADDR_W'(2 * g));
        assign cap_lo_rd[g] = hit(bus_rd, bus_addr, A_CAP0_HI + ADDR_W'(2 * g + 1));

        cct_capture #(.W(CNT_W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_in[g]),
            .rise_sel (ctrla[g]),
            .cnt      (cnt),
            .lock_set (cap_hi_rd[g]),
            .lock_clr (cap_lo_rd[g]),
            .value    (cap_val[g]),
            .evt      (cap_evt[g]),
            .locked   (cap_inh[g])
        );

        assign f_set[F_CAP0 + g] = cap_evt[g];
        assign f_clr[F_CAP0 + g] = armed[F_CAP0 + g] && cap_lo_rd[g];
        assign f_clr[F_CMP0 + g] = armed[F_CMP0 + g] &&
            (hit(bus_rd, bus_addr, A_CMP0_HI + ADDR_W'(2 * g + 1)) ||
             hit(bus_wr, bus_addr, A_CMP0_HI + ADDR_W'(2 * g + 1)));
        assign f_en[F_CAP0 + g]  = ctrla[6];
        assign f_en[F_CMP0 + g]  = ctrla[5];
    end

    assign f_set[F_CMP0]     = m0_evt;
    assign f_set[F_CMP0 + 1] = m1_evt;
    assign f_set[F_OVF]      = ovf_evt;
    assign f_clr[F_OVF]      = armed[F_OVF] && hit(bus_rd, bus_addr, A_CNT_LO);
    assign f_en[F_OVF]       = ctrla[4];

    // flags and their clear arming from a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            armed <= '0;
        end else begin
            flags <= (flags & ~f_clr) | f_set;
            if (hit(bus_rd, bus_addr, A_STAT)) armed <= flags;
            else                               armed <= armed & ~f_clr;
        end
    end

    assign irq = |(flags & f_en);

    cct_clkgen #(.MIN_GAP(MIN_GAP), .PRE_W(3)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .ext_in   (ext_clk),
        .ext_rise (ctrla[7]),
        .tick     (tick)
    );

    cct_count_cmp #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .soft_rst (hit(bus_wr, bus_addr, A_ACNT_LO)),
        .pwm_en   (ctrlb[2]),
        .opm_en   (ctrlb[3]),
        .trig     (cap_evt[0]),
        .cmp0     (cmp_reg[0]),
        .cmp1     (cmp_reg[1]),
        .lvl0     (ctrla[2]),
        .lvl1     (ctrla[3]),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt),
        .m0_evt   (m0_evt),
        .m1_evt   (m1_evt),
        .pin0     (pin0),
        .pin1     (pin1)
    );

    assign cmp_out = {pin1 & ctrlb[5], pin0 & ctrlb[4]};

    // register read mux
    always_comb begin
        case (bus_addr)
            4'd0:    bus_rdata = ctrla;
            4'd1:    bus_rdata = {2'b00, ctrlb};
            4'd2:    bus_rdata = {{(BYTE_W-NFLAG){1'b0}}, flags};
            4'd3:    bus_rdata = cnt[HI:BYTE_W];
            4'd4:    bus_rdata = cnt_bv ? cnt_buf : cnt[BYTE_W-1:0];
            4'd5:    bus_rdata = cnt[HI:BYTE_W];
            4'd6:    bus_rdata = acnt_bv ? acnt_buf : cnt[BYTE_W-1:0];
            4'd7:    bus_rdata = cap_val[0][HI:BYTE_W];
            4'd8:    bus_rdata = cap_val[0][BYTE_W-1:0];
            4'd9:    bus_rdata = cap_val[1][HI:BYTE_W];
            4'd10:   bus_rdata = cap_val[1][BYTE_W-1:0];
            4'd11:   bus_rdata = cmp_reg[0][HI:BYTE_W];
            4'd12:   bus_rdata = cmp_reg[0][BYTE_W-1:0];
            4'd13:   bus_rdata = cmp_reg[1][HI:BYTE_W];
            4'd14:   bus_rdata = cmp_reg[1][BYTE_W-1:0];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_timer_chk.sv
// Property checker for cct_timer, attached by bind. Observes the tick,
// the counter, the overflow flag and the capture lock state.
module cct_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [1:0]  sel,
    input logic [15:0] cnt,
    input logic        ovf_flag,
    input logic [1:0]  cap_inh,
    input logic [15:0] cap0,
    input logic [15:0] cap1
);
    AST_DIV8_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 2'b10 && $past(sel) == 2'b10) |-> !$past(tick)); // R1

    AST_EXT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 2'b11 && $past(sel, 1) == 2'b11 && $past(sel, 2) == 2'b11
         && $past(sel, 3) == 2'b11)
        |-> (!$past(tick, 1) && !$past(tick, 2) && !$past(tick, 3))); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1 || cnt == 16'hFFFC)); // R4

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 16'h0000 && $past(cnt) == 16'hFFFF) |-> ovf_flag); // R5

    AST_CAP0_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_inh[0]) |-> $stable(cap0)); // R8

    AST_CAP1_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_inh[1]) |-> $stable(cap1)); // R8
endmodule

bind cct_timer cct_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sel      (ctrlb[1:0]),
    .cnt      (cnt),
    .ovf_flag (flags[4]),
    .cap_inh  (cap_inh),
    .cap0     (cap_val[0]),
    .cap1     (cap_val[1])
);

// File: tb/cct_timer_tb.sv
module cct_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic [1:0] cap_in = '0;
    logic [1:0] cmp_out;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct { string req; int exp; int act; } item_t;
    item_t sb_q[$];
    event  sb_ev;

    always #4 clk = ~clk;

    cct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    // scoreboard monitor: compare every pushed observation
    task automatic drain();
        while (sb_q.size() > 0) begin
            item_t it = sb_q.pop_front();
            n_run++;
            if (it.act != it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%0h expected=%0h", it.req, it.act, it.exp);
            end
        end
    endtask

    initial forever begin
        @(sb_ev);
        drain();
    end

    task automatic push(input string req, input int act, input int exp);
        item_t it;
        it.req = req; it.act = act; it.exp = exp;
        sb_q.push_back(it);
        ->sb_ev;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rdc(input logic [3:0] a, input int exp, input string req);
        logic [7:0] d;
        rd(a, d);
        push(req, int'(d), exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic chk_sig(input string req, input logic v, input int exp);
        @(negedge clk);
        #2 push(req, int'(v), exp);
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h;
        logic [7:0] l;
        rd(4'd3, h);
        rd(4'd4, l);
        v = {h, l};
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (5) @(negedge clk);
            ext_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic cap_pulse(input int ch);
        @(negedge clk); cap_in[ch] = 1'b1;
        repeat (5) @(negedge clk);
        cap_in[ch] = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ratio_check(input logic [7:0] ctl, input int exp, input string req);
        logic [15:0] v0;
        logic [15:0] v1;
        wr(4'd1, ctl);
        repeat (4) @(negedge clk);
        rd16(v0);
        repeat (62) @(negedge clk);
        rd16(v1);
        push(req, int'(v1 - v0), exp);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // reset values
        rdc(4'd0, 8'h00, "R4 ctrla reset");
        rdc(4'd1, 8'h00, "R1 ctrlb reset");
        rdc(4'd2, 8'h00, "R4 stat reset");
        rdc(4'd11, 8'h80, "R4 cmp0 hi reset");
        rdc(4'd13, 8'h80, "R4 cmp1 hi reset");

        // R1 prescaler ratios
        ratio_check(8'h00, 32, "R1 div2 ticks");
        ratio_check(8'h01, 16, "R1 div4 ticks");
        ratio_check(8'h02, 8,  "R1 div8 ticks");

        // freeze on external source, clear any overflow
        wr(4'd1, 8'h03);
        rdc(4'd1, 8'h03, "R1 ext select");
        begin
            logic [7:0] d;
            rd(4'd2, d);
            rd(4'd4, d);
        end
        rdc(4'd2, 8'h00, "R12 overflow cleared");

        // R4 soft restart
        wr(4'd6, 8'h5A);
        rdc(4'd3, 8'hFF, "R4 restart hi");
        rdc(4'd4, 8'hFC, "R4 restart lo");

        // R2 edge polarity
        wr(4'd0, 8'h80);
        ext_pulse(1);
        rdc(4'd5, 8'hFF, "R2 rising alt hi");
        rdc(4'd6, 8'hFD, "R2 rising alt lo");
        wr(4'd0, 8'h00);
        @(negedge clk); ext_clk = 1'b1;
        repeat (6) @(negedge clk);
        rdc(4'd4, 8'hFD, "R2 falling mode ignores rise");
        ext_clk = 1'b0;
        repeat (6) @(negedge clk);
        rdc(4'd4, 8'hFE, "R2 falling mode counts fall");

        // R5 overflow and R13 interrupt
        wr(4'd0, 8'h80);
        ext_pulse(2);
        rdc(4'd2, 8'h10, "R5 overflow flag");
        chk_sig("R13 irq masked", irq, 0);
        wr(4'd0, 8'h90);
        chk_sig("R13 irq enabled", irq, 1);
        rdc(4'd2, 8'h10, "R12 stat arm");
        rdc(4'd4, 8'h00, "R12 clear access");
        rdc(4'd2, 8'h00, "R12 overflow cleared");
        chk_sig("R13 irq released", irq, 0);

        // R3 minimum external spacing
        wr(4'd0, 8'h80);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            @(negedge clk); ext_clk = 1'b0;
        end
        repeat (8) @(negedge clk);
        rdc(4'd3, 8'h00, "R3 fast ext hi");
        rdc(4'd4, 8'h04, "R3 fast ext lo");

        // R6 coherent read
        rdc(4'd3, 8'h00, "R6 hi read");
        ext_pulse(2);
        rdc(4'd4, 8'h04, "R6 buffered lo");
        rdc(4'd4, 8'h06, "R6 live lo");

        // R7 capture on rising edge of channel 0
        wr(4'd0, 8'h81);
        cap_pulse(0);
        rdc(4'd2, 8'h01, "R7 cap0 flag");
        rdc(4'd7, 8'h00, "R7 cap0 hi");
        rdc(4'd8, 8'h06, "R7 cap0 lo");
        rdc(4'd2, 8'h00, "R12 cap0 flag cleared");

        // R8 lock between high and low reads
        rdc(4'd7, 8'h00, "R8 lock hi");
        ext_pulse(1);
        cap_pulse(0);
        rdc(4'd2, 8'h00, "R8 no flag while locked");
        rdc(4'd8, 8'h06, "R8 value held");
        cap_pulse(0);
        rdc(4'd2, 8'h01, "R8 capture after unlock");
        rdc(4'd8, 8'h07, "R8 new value");

        // R7 channel 1 on falling edge
        cap_pulse(1);
        rdc(4'd2, 8'h02, "R7 cap1 falling flag");
        rdc(4'd9, 8'h00, "R7 cap1 hi");
        rdc(4'd10, 8'h07, "R7 cap1 lo");
        rdc(4'd2, 8'h00, "R12 cap1 cleared");

        // R9 normal compare
        wr(4'd0, 8'hAC);
        wr(4'd1, 8'h33);
        wr(4'd11, 8'h00); wr(4'd12, 8'h09);
        wr(4'd13, 8'h00); wr(4'd14, 8'h0A);
        chk_sig("R9 pin0 idle", cmp_out[0], 0);
        chk_sig("R13 irq idle", irq, 0);
        ext_pulse(2);
        chk_sig("R9 pin0 on match", cmp_out[0], 1);
        chk_sig("R9 pin1 before match", cmp_out[1], 0);
        chk_sig("R13 irq on compare", irq, 1);
        ext_pulse(1);
        chk_sig("R9 pin1 on match", cmp_out[1], 1);
        rdc(4'd2, 8'h0C, "R9 compare flags");
        wr(4'd12, 8'h09);
        wr(4'd14, 8'h0A);
        rdc(4'd2, 8'h00, "R12 compare flags cleared by write");
        chk_sig("R13 irq cleared", irq, 0);

        // R10 waveform mode
        wr(4'd0, 8'h88);
        wr(4'd11, 8'hFF); wr(4'd12, 8'hFE);
        wr(4'd13, 8'h00); wr(4'd14, 8'h01);
        wr(4'd1, 8'h17);
        wr(4'd6, 8'h00);
        chk_sig("R10 level at restart", cmp_out[0], 1);
        ext_pulse(2);
        chk_sig("R10 level at compare 0", cmp_out[0], 0);
        ext_pulse(3);
        chk_sig("R10 level held", cmp_out[0], 0);
        ext_pulse(1);
        chk_sig("R10 level at period end", cmp_out[0], 1);
        rdc(4'd3, 8'hFF, "R10 restart hi");
        rdc(4'd4, 8'hFC, "R10 restart lo");
        rdc(4'd2, 8'h10, "R10 no compare flags");

        // R11 single-pulse mode
        do_reset();
        wr(4'd1, 8'h1B);
        wr(4'd0, 8'h89);
        wr(4'd11, 8'hFF); wr(4'd12, 8'hFE);
        chk_sig("R11 idle level", cmp_out[0], 0);
        cap_pulse(0);
        chk_sig("R11 pulse start", cmp_out[0], 1);
        rdc(4'd3, 8'hFF, "R11 restart hi");
        rdc(4'd4, 8'hFC, "R11 restart lo");
        ext_pulse(2);
        chk_sig("R11 pulse end", cmp_out[0], 0);

        repeat (4) @(negedge clk);
        drain();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule